// File: doc/BRIEF.md
# Multi-Slot Masked I2C Address Matcher

This block listens to an I2C bus as a slave and decides, for every address byte that follows a START or repeated START, whether the device should acknowledge it. It has four independent address slots. Each slot has a 7-bit address, a per-bit "don't care" mask and its own enable for the general-call address. Software programs the slots through a small synchronous register bus. Reads on that bus are combinational.

SCL and SDA each pass through a two-flop synchronizer. After a START the block shifts in seven address bits, MSB first, followed by the R/W bit, each taken on a rising edge of SCL. It then compares the 7-bit address against all slots in parallel. On a hit it pulls SDA low for the ninth clock. It also raises a one-cycle match pulse with the index of the winning slot and a general-call flag, and it latches the whole received byte into a readable register. When no slot hits, it leaves SDA released and ignores the bus until the next START.

Top module: `i2c_multi_addr_match`

## Requirements
- R1: Register offsets 0 to 3 are the address slots 0 to 3. Bits 7:1 hold the slave address and bit 0 enables general call. The low byte of a write is stored, and bits 31:8 read as zero.
- R2: Register offsets 4 to 7 are the masks of slots 0 to 3. Only bits 7:1 are stored. Bit 0 and bits 31:8 ignore writes and read as zero.
- R3: Register offset 8 is read-only. It holds the last matched byte, with the address in bits 7:1 and R/W in bit 0. It changes only together with a match pulse.
- R4: After reset every address, mask and data register reads zero, SDA is released and no match pulse is present.
- R5: A non-zero received 7-bit address hits a slot when the slot value is not 0x00 and the address equals the slot address on every bit whose mask bit is 0.
- R6: A slot whose 8-bit value is 0x00 never hits.
- R7: A received address of 0000000 is a general call. Only slots with bit 0 set accept it, masks play no part, and slots with bit 0 clear never accept it.
- R8: On a hit, SDA is pulled low from the SCL fall that ends the R/W bit until the SCL fall that ends the ninth clock. At all other times SDA is released.
- R9: On a miss, SDA is not pulled low and no match pulse occurs. Further bytes are ignored until a START or repeated START, which restarts address collection.
- R10: A hit raises matchPulse for exactly one clock. matchSlot gives the lowest-numbered slot that hit, and matchGc is 1 exactly when the address was 0000000.
- R11: Address bits are taken MSB first on SCL rising edges after a START. The eighth bit is R/W and plays no part in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset (word index) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| sclIn | input | 1 | SCL line as seen on the bus |
| sdaIn | input | 1 | SDA line as seen on the bus |
| sdaPullLow | output | 1 | 1 = pull SDA low (open-drain acknowledge) |
| matchPulse | output | 1 | One-cycle pulse when an address byte hits |
| matchSlot | output | 2 | Lowest slot index that hit |
| matchGc | output | 1 | The hit was a general call |

## Verification
The bench goes after the cases that separate a masked compare from a naive one. In one case a slot is fully masked but has general call off, so a design that applied masks to general call would acknowledge 0x00. In another, slot value 0x00 must stay silent for address 0, so a design that only checks address equality would answer. Overlapping slots check the priority order: a design that encodes the highest or the last index reports the wrong slot. A miss followed by a matching byte with no new START catches a design that keeps decoding bytes after it should have stopped. Random slot, mask and address patterns, biased toward near-hits, are compared against a bench model for acknowledge, slot, flag and latched byte.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef struct packed {
    logic clearShift;
    logic shiftEn;
    logic shiftBit;
    logic evalNow;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_EVAL,
    ST_ACKWAIT,
    ST_ACK,
    ST_SKIP
  } ctrlState_t;

endpackage

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_BITS   = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        anyHit,
  output ctrlStrobe_t strobe,
  output logic        ackDrive
);

  localparam int FRAME_BITS = ADDR_BITS + 1;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic sclRise, sclFall, startSeen, stopSeen;
  ctrlState_t state;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow    = sclSync[SYNC_STAGES-1];
  assign sdaNow    = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (startSeen) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopSeen) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_ADDR: if (sclRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == CNT_W'(FRAME_BITS - 1)) state <= ST_EVAL;
        end
        ST_EVAL:    state <= anyHit ? ST_ACKWAIT : ST_SKIP;
        ST_ACKWAIT: if (sclFall) state <= ST_ACK;
        ST_ACK:     if (sclFall) state <= ST_SKIP;
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.clearShift = startSeen;
    strobe.shiftEn    = (state == ST_ADDR) && sclRise && !startSeen && !stopSeen;
    strobe.shiftBit   = sdaNow;
    strobe.evalNow    = (state == ST_EVAL) && !startSeen && !stopSeen;
  end

  assign ackDrive = (state == ST_ACK);

endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_BITS = 7,
  parameter int REG_AW    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWr,
  input  logic [REG_AW-1:0]            regAddr,
  input  logic [DATA_W-1:0]            regWdata,
  output logic [DATA_W-1:0]            regRdata,
  input  ctrlStrobe_t                  strobe,
  output logic                         anyHit,
  output logic                         matchPulse,
  output logic [$clog2(NUM_SLOTS)-1:0] matchSlot,
  output logic                         matchGc,
  output logic [ADDR_BITS:0]           rxLatched
);

  localparam int FRAME_BITS = ADDR_BITS + 1;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int MASK_BASE  = NUM_SLOTS;
  localparam int DATA_IDX   = 2 * NUM_SLOTS;

  logic [NUM_SLOTS-1:0][FRAME_BITS-1:0] adrBus;
  logic [NUM_SLOTS-1:0][ADDR_BITS-1:0]  mskBus;
  logic [NUM_SLOTS-1:0]                 slotHit;
  logic [FRAME_BITS-1:0]                shiftQ, dataQ;
  logic [ADDR_BITS-1:0]                 rxAddr;
  logic                                 rxIsGc;
  logic [SLOT_W-1:0]                    hitIdx;

  assign rxAddr = shiftQ[FRAME_BITS-1:1];
  assign rxIsGc = (rxAddr == '0);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [FRAME_BITS-1:0] adrQ;
    logic [ADDR_BITS-1:0]  mskQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        adrQ <= '0;
        mskQ <= '0;
      end else if (regWr) begin
        if (regAddr == REG_AW'(s))             adrQ <= regWdata[FRAME_BITS-1:0];
        if (regAddr == REG_AW'(MASK_BASE + s)) mskQ <= regWdata[FRAME_BITS-1:1];
      end
    end
    assign adrBus[s]  = adrQ;
    assign mskBus[s]  = mskQ;
    assign slotHit[s] = rxIsGc ? adrQ[0]
                      : ((|adrQ) && (((rxAddr ^ adrQ[FRAME_BITS-1:1]) & ~mskQ) == '0));
  end

  assign anyHit = |slotHit;

  always_comb begin
    hitIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (slotHit[i]) hitIdx = SLOT_W'(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ     <= '0;
      dataQ      <= '0;
      matchPulse <= 1'b0;
      matchSlot  <= '0;
      matchGc    <= 1'b0;
    end else begin
      if (strobe.clearShift)   shiftQ <= '0;
      else if (strobe.shiftEn) shiftQ <= {shiftQ[FRAME_BITS-2:0], strobe.shiftBit};
      matchPulse <= strobe.evalNow && anyHit;
      if (strobe.evalNow && anyHit) begin
        matchSlot <= hitIdx;
        matchGc   <= rxIsGc;
        dataQ     <= shiftQ;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (regAddr == REG_AW'(i))             regRdata[FRAME_BITS-1:0] = adrBus[i];
      if (regAddr == REG_AW'(MASK_BASE + i)) regRdata[FRAME_BITS-1:1] = mskBus[i];
    end
    if (regAddr == REG_AW'(DATA_IDX)) regRdata[FRAME_BITS-1:0] = dataQ;
  end

  assign rxLatched = dataQ;

endmodule

// File: rtl/i2c_multi_addr_match.sv
module i2c_multi_addr_match
  import i2cm_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int ADDR_BITS   = 7,
  parameter int REG_AW      = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWr,
  input  logic [REG_AW-1:0]            regAddr,
  input  logic [DATA_W-1:0]            regWdata,
  output logic [DATA_W-1:0]            regRdata,
  input  logic                         sclIn,
  input  logic                         sdaIn,
  output logic                         sdaPullLow,
  output logic                         matchPulse,
  output logic [$clog2(NUM_SLOTS)-1:0] matchSlot,
  output logic                         matchGc
);

  ctrlStrobe_t        strobe;
  logic               anyHit;
  logic [ADDR_BITS:0] rxLatched;

  i2cm_ctrl #(.SYNC_STAGES(SYNC_STAGES), .ADDR_BITS(ADDR_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .anyHit(anyHit), .strobe(strobe), .ackDrive(sdaPullLow)
  );

  i2cm_datapath #(.NUM_SLOTS(NUM_SLOTS), .ADDR_BITS(ADDR_BITS),
                  .REG_AW(REG_AW), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strobe(strobe),
    .anyHit(anyHit), .matchPulse(matchPulse), .matchSlot(matchSlot),
    .matchGc(matchGc), .rxLatched(rxLatched)
  );

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_BITS = 7,
  parameter int REG_AW    = 4,
  parameter int DATA_W    = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               matchPulse,
  input logic               matchGc,
  input logic               sdaPullLow,
  input logic [ADDR_BITS:0] rxLatched,
  input logic [REG_AW-1:0]  regAddr,
  input logic [DATA_W-1:0]  regRdata
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           armed <= 1'b0;
    else if (matchPulse) armed <= 1'b1;
    else if (sdaPullLow) armed <= 1'b0;
  end

  // R10: pulse lasts one clock
  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse);

  // R8: acknowledge only follows a reported hit
  assert_ack_after_hit_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> armed);

  // R3: latched byte moves only with a match pulse
  assert_data_with_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxLatched) |-> matchPulse);

  // R7: general-call flag means an all-zero address
  assert_gc_flag_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && matchGc) |-> (rxLatched[ADDR_BITS:1] == '0));

  // R2: reserved mask bits read zero
  assert_mask_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((regAddr >= REG_AW'(NUM_SLOTS)) && (regAddr < REG_AW'(2 * NUM_SLOTS)))
      |-> (regRdata[0] == 1'b0 && regRdata[DATA_W-1:ADDR_BITS+1] == '0));

endmodule

bind i2c_multi_addr_match i2cm_checker #(
  .NUM_SLOTS(NUM_SLOTS), .ADDR_BITS(ADDR_BITS), .REG_AW(REG_AW), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .matchPulse(matchPulse), .matchGc(matchGc),
  .sdaPullLow(sdaPullLow), .rxLatched(rxLatched), .regAddr(regAddr),
  .regRdata(regRdata)
);

// File: tb/sim_i2c_multi_addr_match.sv
`timescale 1ns/1ps
module sim_i2c_multi_addr_match;

  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sclM = 1'b1, sdaM = 1'b1;
  wire         sdaLine;
  logic        sdaPullLow, matchPulse, matchGc;
  logic [1:0]  matchSlot;

  int checks = 0, errors = 0, pulseCnt = 0;
  logic [1:0] lastSlot = '0;
  logic       lastGc = 1'b0;
  bit         done = 1'b0;
  logic [7:0] shAdr [4];
  logic [7:0] shMsk [4];

  always #2 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullLow;

  i2c_multi_addr_match u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .matchPulse(matchPulse), .matchSlot(matchSlot),
    .matchGc(matchGc)
  );

  always @(negedge clk) if (rstN && matchPulse) begin
    pulseCnt++;
    lastSlot = matchSlot;
    lastGc = matchGc;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic waitH(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
    if (a < 4) shAdr[a[1:0]] = d[7:0];
    else if (a < 8) shMsk[a[1:0]] = {d[7:1], 1'b0};
  endtask

  task automatic readReg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  function automatic void model(input logic [7:0] rx, output bit hit,
                                output int slot, output bit gc);
    logic [6:0] a;
    bit h;
    a = rx[7:1];
    hit = 1'b0; slot = 0; gc = (a == 7'd0);
    for (int i = 3; i >= 0; i--) begin
      if (a == 7'd0) h = shAdr[i][0];
      else h = (shAdr[i] != 8'd0) && (((a ^ shAdr[i][7:1]) & ~shMsk[i][7:1]) == 7'd0);
      if (h) begin hit = 1'b1; slot = i; end
    end
  endfunction

  task automatic i2cStart();
    sdaM = 1'b1; waitH(H);
    sclM = 1'b1; waitH(H);
    sdaM = 1'b0; waitH(H);
    sclM = 1'b0; waitH(H);
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitH(H);
    sclM = 1'b1; waitH(H);
    sdaM = 1'b1; waitH(H);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitH(H);
    sclM = 1'b1; waitH(H);
    sclM = 1'b0; waitH(H);
  endtask

  // sends one byte plus the ninth clock; checks acknowledge, pulse, slot, flag, data
  task automatic sendByte(input logic [7:0] rx, input bit ignoring, input string req);
    bit hit, gc, ackAll, ackAny;
    int slot, p0;
    logic [31:0] v;
    model(rx, hit, slot, gc);
    if (ignoring) hit = 1'b0;
    p0 = pulseCnt;
    for (int i = 7; i >= 0; i--) sendBit(rx[i]);
    sdaM = 1'b1; waitH(H);
    sclM = 1'b1;
    ackAll = 1'b1; ackAny = 1'b0;
    for (int i = 0; i < H; i++) begin
      @(negedge clk);
      ackAll &= ~sdaLine;
      ackAny |= ~sdaLine;
    end
    sclM = 1'b0; waitH(H);
    check(hit ? ackAll : !ackAny, req, $sformatf("ack for byte %02h", rx),
          int'(ackAny), int'(hit));
    check(sdaPullLow == 1'b0, "R8", "SDA released after ninth clock", int'(sdaPullLow), 0);
    check(pulseCnt - p0 == int'(hit), "R10", $sformatf("pulse count for %02h", rx),
          pulseCnt - p0, int'(hit));
    if (hit) begin
      check(int'(lastSlot) == slot, "R10", "reported slot", int'(lastSlot), slot);
      check(lastGc == gc, "R7", "general-call flag", int'(lastGc), int'(gc));
      readReg(4'd8, v);
      check(v == {24'd0, rx}, "R3", "latched byte", int'(v), int'(rx));
    end
  endtask

  task automatic fullXfer(input logic [7:0] rx, input string req);
    i2cStart();
    sendByte(rx, 1'b0, req);
    i2cStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, keep;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) begin shAdr[i] = '0; shMsk[i] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    waitH(2);

    // R4: reset state
    for (int a = 0; a < 9; a++) begin
      readReg(4'(a), v);
      check(v == 32'd0, "R4", $sformatf("reset value of reg %0d", a), int'(v), 0);
    end
    check(sdaPullLow == 1'b0 && matchPulse == 1'b0, "R4", "outputs idle after reset",
          int'({sdaPullLow, matchPulse}), 0);

    // R1 / R2: stored widths
    writeReg(4'd1, 32'hFFFF_FF5A);
    readReg(4'd1, v);
    check(v == 32'h5A, "R1", "slot keeps low byte only", int'(v), 32'h5A);
    writeReg(4'd4, 32'hFFFF_FFFF);
    readReg(4'd4, v);
    check(v == 32'hFE, "R2", "mask reserved bits", int'(v), 32'hFE);
    writeReg(4'd1, 0); writeReg(4'd4, 0);

    // R6: all slots disabled
    fullXfer(8'h00, "R6");
    fullXfer(8'hA4, "R6");

    // R7 / R5: general call vs masks
    writeReg(4'd0, 32'h01);
    writeReg(4'd1, 32'h20);
    writeReg(4'd5, 32'hFE);
    fullXfer(8'h00, "R7");
    writeReg(4'd0, 32'h00);
    fullXfer(8'h01, "R7");
    fullXfer(8'h5E, "R5");
    readReg(4'd8, keep);
    fullXfer(8'h00, "R7");
    readReg(4'd8, v);
    check(v == keep, "R3", "data unchanged after miss", int'(v), int'(keep));

    // R10: overlapping slots, lowest wins; R11: R/W bit not compared
    writeReg(4'd1, 32'h00); writeReg(4'd5, 32'h00);
    writeReg(4'd2, 32'h40); writeReg(4'd6, 32'h0E);
    writeReg(4'd3, 32'h42);
    fullXfer(8'h43, "R10");
    check(lastSlot == 2'd2, "R10", "priority to slot 2", int'(lastSlot), 2);
    fullXfer(8'h42, "R11");
    fullXfer(8'h86, "R11");

    // R9: miss ignores later bytes until a repeated START
    i2cStart();
    sendByte(8'h10, 1'b0, "R9");
    sendByte(8'h42, 1'b1, "R9");
    i2cStart();
    sendByte(8'h42, 1'b0, "R9");
    i2cStop();

    // random patterns against the model
    for (int cfg = 0; cfg < 6; cfg++) begin
      for (int s = 0; s < 4; s++) begin
        logic [7:0] ad;
        ad = 8'($urandom);
        if ($urandom % 4 == 0) ad = 8'h00;
        writeReg(4'(s), {24'd0, ad});
        writeReg(4'(s + 4), 32'($urandom & $urandom & 32'hFF));
      end
      for (int t = 0; t < 8; t++) begin
        logic [7:0] rx;
        int k;
        k = $urandom % 4;
        if ($urandom % 2 == 0)
          rx = {(shAdr[k][7:1] & ~shMsk[k][7:1]) | (7'($urandom) & shMsk[k][7:1]),
                1'($urandom)};
        else if ($urandom % 5 == 0)
          rx = {7'd0, 1'($urandom)};
        else
          rx = 8'($urandom);
        fullXfer(rx, "R5");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule